// File: doc/BRIEF.md
# Prefix-extended store-byte address builder

This block sits behind the decoder of a small 16-bit core. It forms the absolute byte address for a store-byte instruction whose operand is an immediate address. On its own, the store carries only a 7-bit unsigned immediate. One or two extension prefix instructions, decoded just before the store, can widen that immediate to 20 or 24 bits. The block watches the decoded strobes and keeps the pending prefix values. When the store arrives, it issues one registered byte write: the address it has built, and the low byte of the chosen general register.

Each prefix carries a 13-bit value. When only one prefix is pending, its value becomes address bits 19:7. When two are pending, the most recent one gives bits 19:7, and the low four bits of the earlier one give bits 23:20. The store's own immediate always fills bits 6:0. A store in a branch delay slot never uses prefixes. Any instruction other than a prefix discards whatever is pending.

The decode strobes are mutually exclusive: at most one of the prefix, store and other-instruction strobes is high in any cycle.

Top module: `imm_addr_ext`

## Requirements
- R1: A store with no pending prefix writes to its 7-bit immediate, zero-extended to 24 bits.
- R2: A store after a single prefix writes to the address {4'b0, prefix[12:0], imm[6:0]}. For example, prefix 0x1 with immediate 0x1 gives address 0x81.
- R3: A store after two prefixes writes to {first[3:0], second[12:0], imm[6:0]}. Bits 12:4 of the first prefix have no effect on the address.
- R4: The write data is the low byte of the register selected by the 3-bit index (0 to 7). Lane k of the 64-bit lane input, bits 8k+7:8k, holds the low byte of register rk.
- R5: A store whose delay-slot flag is set writes to its zero-extended 7-bit immediate, even when prefixes are pending. The pending prefixes are discarded.
- R6: The write enable is high for exactly the one cycle after each clock edge at which a store strobe is sampled, with address and data valid in that cycle. Back-to-back stores give back-to-back write cycles. Between writes, the address and data hold their last values.
- R7: A third consecutive prefix replaces the oldest pending one, so only the two most recent prefixes are used.
- R8: A store or any other non-prefix instruction clears all pending prefixes, so the next store without new prefixes uses the R1 address.
- R9: After reset, the write enable, address and data are zero and no prefix is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pfx_valid | input | 1 | A decoded extension prefix is present this cycle |
| pfx_imm | input | 13 | Immediate carried by the prefix |
| st_valid | input | 1 | A decoded store-byte-to-immediate-address is present this cycle |
| st_imm | input | 7 | 7-bit unsigned immediate of the store |
| st_src_sel | input | 3 | Source register index (r0 to r7) |
| st_delay_slot | input | 1 | The store executes in a branch delay slot |
| other_valid | input | 1 | Some other non-prefix instruction is decoded this cycle |
| src_lanes | input | 64 | Low byte of each general register, with lane k for rk |
| wr_en | output | 1 | Byte write strobe |
| wr_addr | output | 24 | Byte write address |
| wr_data | output | 8 | Byte write data |

## Verification
A prefix or other-instruction strobe changes only the internal pending state, which is registered at the next edge. A store's write enable, address and data appear registered one edge after the store strobe is sampled. The bench drives every strobe on a falling edge and holds it for one full cycle. It then reads the write outputs at the very next falling edge, half a cycle after the capturing rising edge. It also checks that the write enable has dropped one falling edge later. The effect of a prefix or of a clearing instruction is observed only through the address of the store that follows it.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  // Number of prefix values currently pending.
  typedef enum logic [1:0] {
    DEPTH_NONE = 2'd0,
    DEPTH_ONE  = 2'd1,
    DEPTH_TWO  = 2'd2
  } depth_e;
endpackage

// File: rtl/pfx_queue.sv
module pfx_queue
  import pfx_pkg::*;
#(
  parameter int EXT_W = 13,
  parameter int TOP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             flush,
  input  logic [EXT_W-1:0] push_val,
  output logic [TOP_W-1:0] older_top,
  output logic [EXT_W-1:0] newer,
  output depth_e           depth
);

  // Two-deep shift of the most recent prefixes; the older slot only needs
  // the bits that reach the top of the address.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth     <= DEPTH_NONE;
      older_top <= '0;
      newer     <= '0;
    end else if (flush) begin
      depth <= DEPTH_NONE;
    end else if (push) begin
      newer <= push_val;
      if (depth == DEPTH_NONE) begin
        depth <= DEPTH_ONE;
      end else begin
        older_top <= newer[TOP_W-1:0];
        depth     <= DEPTH_TWO;
      end
    end
  end

  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> depth == DEPTH_NONE);

  p_depth_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    depth != 2'd3);

  p_shift_keeps_two_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !flush && depth != DEPTH_NONE) |=>
      (depth == DEPTH_TWO && older_top == $past(newer[TOP_W-1:0])));

endmodule

// File: rtl/addr_compose.sv
module addr_compose
  import pfx_pkg::*;
#(
  parameter int IMM_W = 7,
  parameter int EXT_W = 13,
  parameter int TOP_W = 4
) (
  input  depth_e                         depth,
  input  logic                           delay_slot,
  input  logic [TOP_W-1:0]               older_top,
  input  logic [EXT_W-1:0]               newer,
  input  logic [IMM_W-1:0]               imm,
  output logic [TOP_W+EXT_W+IMM_W-1:0]   addr
);
  localparam int ADDR_W = TOP_W + EXT_W + IMM_W;

  function automatic logic [ADDR_W-1:0] build_addr(
    input depth_e           d,
    input logic             dly,
    input logic [TOP_W-1:0] hi,
    input logic [EXT_W-1:0] mid,
    input logic [IMM_W-1:0] lo
  );
    logic [ADDR_W-1:0] a;
    a = '0;
    a[IMM_W-1:0] = lo;
    if (!dly && d != DEPTH_NONE) a[IMM_W +: EXT_W] = mid;
    if (!dly && d == DEPTH_TWO)  a[IMM_W+EXT_W +: TOP_W] = hi;
    return a;
  endfunction

  always_comb addr = build_addr(depth, delay_slot, older_top, newer, imm);

endmodule

// File: rtl/lane_select.sv
module lane_select #(
  parameter int NREG   = 8,
  parameter int BYTE_W = 8,
  localparam int SEL_W = $clog2(NREG)
) (
  input  logic [NREG*BYTE_W-1:0] lanes,
  input  logic [SEL_W-1:0]       sel,
  output logic [BYTE_W-1:0]      byte_out
);
  logic [BYTE_W-1:0] lane [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_lane
    assign lane[g] = lanes[g*BYTE_W +: BYTE_W];
  end

  always_comb byte_out = lane[sel];

endmodule

// File: rtl/store_issue.sv
module store_issue #(
  parameter int ADDR_W = 24,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [BYTE_W-1:0] data_in,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= fire;
      if (fire) begin
        wr_addr <= addr_in;
        wr_data <= data_in;
      end
    end
  end

  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> ($stable(wr_addr) && $stable(wr_data)));

endmodule

// File: rtl/imm_addr_ext.sv
module imm_addr_ext
  import pfx_pkg::*;
#(
  parameter int IMM_W  = 7,
  parameter int EXT_W  = 13,
  parameter int TOP_W  = 4,
  parameter int NREG   = 8,
  parameter int BYTE_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         pfx_valid,
  input  logic [EXT_W-1:0]             pfx_imm,
  input  logic                         st_valid,
  input  logic [IMM_W-1:0]             st_imm,
  input  logic [$clog2(NREG)-1:0]      st_src_sel,
  input  logic                         st_delay_slot,
  input  logic                         other_valid,
  input  logic [NREG*BYTE_W-1:0]       src_lanes,
  output logic                         wr_en,
  output logic [TOP_W+EXT_W+IMM_W-1:0] wr_addr,
  output logic [BYTE_W-1:0]            wr_data
);
  localparam int ADDR_W = TOP_W + EXT_W + IMM_W;

  // Named internal events for the checks below.
  logic              consume;
  depth_e            pend_depth;
  logic [TOP_W-1:0]  pend_top;
  logic [EXT_W-1:0]  pend_mid;
  logic [ADDR_W-1:0] next_addr;
  logic [BYTE_W-1:0] next_byte;

  assign consume = st_valid | other_valid;

  pfx_queue #(.EXT_W(EXT_W), .TOP_W(TOP_W)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(pfx_valid), .flush(consume),
    .push_val(pfx_imm), .older_top(pend_top), .newer(pend_mid),
    .depth(pend_depth)
  );

  addr_compose #(.IMM_W(IMM_W), .EXT_W(EXT_W), .TOP_W(TOP_W)) u_compose (
    .depth(pend_depth), .delay_slot(st_delay_slot), .older_top(pend_top),
    .newer(pend_mid), .imm(st_imm), .addr(next_addr)
  );

  lane_select #(.NREG(NREG), .BYTE_W(BYTE_W)) u_select (
    .lanes(src_lanes), .sel(st_src_sel), .byte_out(next_byte)
  );

  store_issue #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_issue (
    .clk(clk), .rst_n(rst_n), .fire(st_valid), .addr_in(next_addr),
    .data_in(next_byte), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pfx_valid, st_valid, other_valid}));

  p_we_on_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |=> wr_en);

  p_we_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !st_valid |=> !wr_en);

  p_low_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |=> wr_addr[IMM_W-1:0] == $past(st_imm));

  p_bare_short_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && pend_depth == DEPTH_NONE) |=> wr_addr[ADDR_W-1:IMM_W] == '0);

  p_delay_short_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_delay_slot) |=> wr_addr[ADDR_W-1:IMM_W] == '0);

  p_one_pfx_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_delay_slot && pend_depth == DEPTH_ONE) |=>
      wr_addr[ADDR_W-1:IMM_W+EXT_W] == '0);

  p_data_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |=> wr_data == $past(src_lanes[st_src_sel*BYTE_W +: BYTE_W]));

endmodule

// File: tb/tb_imm_addr_ext.sv
`timescale 1ns/1ps
module tb_imm_addr_ext;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pfx_valid = 1'b0;
  logic [12:0] pfx_imm = '0;
  logic        st_valid = 1'b0;
  logic [6:0]  st_imm = '0;
  logic [2:0]  st_src_sel = '0;
  logic        st_delay_slot = 1'b0;
  logic        other_valid = 1'b0;
  logic [63:0] src_lanes = '0;
  logic        wr_en;
  logic [23:0] wr_addr;
  logic [7:0]  wr_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  imm_addr_ext dut (
    .clk(clk), .rst_n(rst_n), .pfx_valid(pfx_valid), .pfx_imm(pfx_imm),
    .st_valid(st_valid), .st_imm(st_imm), .st_src_sel(st_src_sel),
    .st_delay_slot(st_delay_slot), .other_valid(other_valid),
    .src_lanes(src_lanes), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // Lane k holds a distinct byte for register rk.
  function automatic logic [7:0] lane_val(input int k);
    return 8'(8'h3C + k * 8'h17);
  endfunction

  // Address as top*2^20 + mid*2^7 + imm.
  function automatic logic [23:0] want_addr(input int top, input int mid, input int imm);
    return 24'((top % 16) * 1048576 + (mid % 8192) * 128 + (imm % 128));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // All tasks start and end on a falling edge.
  task automatic send_pfx(input logic [12:0] v);
    pfx_valid = 1'b1; pfx_imm = v;
    @(negedge clk);
    pfx_valid = 1'b0;
  endtask

  task automatic send_other();
    other_valid = 1'b1;
    @(negedge clk);
    other_valid = 1'b0;
  endtask

  task automatic send_store(input logic [6:0] imm, input logic [2:0] sel, input logic dly);
    st_valid = 1'b1; st_imm = imm; st_src_sel = sel; st_delay_slot = dly;
    @(negedge clk);
    st_valid = 1'b0; st_delay_slot = 1'b0;
  endtask

  task automatic idle_low(input string tag);
    @(negedge clk);
    chk(tag, {31'b0, wr_en}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R9 wr_en after reset", {31'b0, wr_en}, 32'd0);
    chk("R9 addr after reset", {8'b0, wr_addr}, 32'd0);
    chk("R9 data after reset", {24'b0, wr_data}, 32'd0);
    send_store(7'h6B, 3'd2, 1'b0);
    chk("R9 first store no pending", {8'b0, wr_addr}, {8'b0, want_addr(0, 0, 'h6B)});
    idle_low("R6 pulse after first store");
  endtask

  task automatic t_bare();
    send_store(7'h55, 3'd3, 1'b0);
    chk("R1 bare addr", {8'b0, wr_addr}, {8'b0, want_addr(0, 0, 'h55)});
    chk("R4 data r3", {24'b0, wr_data}, {24'b0, lane_val(3)});
    chk("R6 we high", {31'b0, wr_en}, 32'd1);
    idle_low("R6 we drops");
    chk("R6 addr held", {8'b0, wr_addr}, {8'b0, want_addr(0, 0, 'h55)});
    chk("R6 data held", {24'b0, wr_data}, {24'b0, lane_val(3)});
  endtask

  task automatic t_one();
    send_pfx(13'h1);
    send_store(7'h1, 3'd0, 1'b0);
    chk("R2 example 0x81", {8'b0, wr_addr}, 32'h81);
    chk("R4 data r0", {24'b0, wr_data}, {24'b0, lane_val(0)});
    send_pfx(13'h1ABC);
    @(negedge clk);
    send_store(7'h7F, 3'd5, 1'b0);
    chk("R2 wide one prefix", {8'b0, wr_addr}, {8'b0, want_addr(0, 'h1ABC, 'h7F)});
    idle_low("R6 after one prefix store");
  endtask

  task automatic t_two();
    send_pfx(13'h1235);
    send_pfx(13'h0F0F);
    send_store(7'h22, 3'd6, 1'b0);
    chk("R3 two prefixes", {8'b0, wr_addr}, {8'b0, want_addr('h5, 'h0F0F, 'h22)});
    chk("R4 data r6", {24'b0, wr_data}, {24'b0, lane_val(6)});
  endtask

  task automatic t_three();
    send_pfx(13'h000A);
    send_pfx(13'h1FFB);
    send_pfx(13'h003C);
    send_store(7'h40, 3'd1, 1'b0);
    chk("R7 oldest dropped", {8'b0, wr_addr}, {8'b0, want_addr('hB, 'h3C, 'h40)});
  endtask

  task automatic t_delay();
    send_pfx(13'h1FFF);
    send_pfx(13'h0007);
    send_store(7'h11, 3'd4, 1'b1);
    chk("R5 delay slot short", {8'b0, wr_addr}, {8'b0, want_addr(0, 0, 'h11)});
    send_store(7'h12, 3'd4, 1'b0);
    chk("R5 pending discarded", {8'b0, wr_addr}, {8'b0, want_addr(0, 0, 'h12)});
    chk("R6 back-to-back we", {31'b0, wr_en}, 32'd1);
    idle_low("R6 after back-to-back");
  endtask

  task automatic t_other();
    send_pfx(13'h0055);
    send_other();
    send_store(7'h03, 3'd7, 1'b0);
    chk("R8 other clears", {8'b0, wr_addr}, {8'b0, want_addr(0, 0, 'h03)});
    chk("R4 data r7", {24'b0, wr_data}, {24'b0, lane_val(7)});
    send_pfx(13'h0101);
    send_store(7'h04, 3'd0, 1'b0);
    send_store(7'h05, 3'd0, 1'b0);
    chk("R8 store clears", {8'b0, wr_addr}, {8'b0, want_addr(0, 0, 'h05)});
  endtask

  task automatic t_lanes();
    for (int k = 0; k < 8; k++) begin
      send_store(7'(k), 3'(k), 1'b0);
      chk($sformatf("R4 lane %0d", k), {24'b0, wr_data}, {24'b0, lane_val(k)});
    end
    idle_low("R6 after lane sweep");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 8; k++) src_lanes[k*8 +: 8] = lane_val(k);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bare();
    t_one();
    t_two();
    t_three();
    t_delay();
    t_other();
    t_lanes();
    finish_run();
  end
endmodule